// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block sits beside a block-interleaved multithreaded pipeline and decides when the pipeline should give up its running hardware context for another one. The pipeline keeps running one thread until an event makes waiting costly. The controller watches several sources of such events and turns the enabled ones into a switch decision. The sources are the decoded instruction (its class, or an explicit switch instruction that may carry a predicate), data-cache miss reports from a late stage, an external event line, and load issue and return traffic.

For the lazy switch-on-use policy it keeps a valid bit for every register of every context. Issuing a load clears the bit of its destination register, and returning load data sets it again. A switch then happens only when the running thread decodes an instruction that reads a register still waiting for data.

When a trigger fires and another context is ready, the controller raises a switch request and names the next context in round-robin order after the current one. In the following cycle it raises a one-cycle flush and the new context becomes the current one. The pipeline uses the flush to discard the work in flight for the old context.

Top module: `thread_switch_ctrl`

## Requirements
- R1: A synchronous active-low reset sets the current context to 0, drops flush and marks every register of every context valid, so an instruction read in switch-on-use mode causes no switch after reset.
- R2: With mode bit 0 set, a decoded switch instruction (`dec_valid` and `dec_is_switch`) that is unpredicated raises `switch_req` in the same cycle.
- R3: A predicated switch instruction (`dec_sw_pred_en` high) switches only when `dec_sw_cond` is 1. With `dec_sw_cond` at 0 it has no effect on `switch_req`, `cur_tid` or `flush`.
- R4: With mode bit 1 set, a decoded instruction switches when it belongs to a selected class. `class_sel` bit 0 selects memory instructions (`dec_is_mem`) and bit 1 selects hard-to-predict branches (`dec_is_hard_br`). An instruction of a class that is not selected does not switch.
- R5: With mode bit 2 set, a data-cache miss report (`miss_rpt`) raises `switch_req` in the same cycle.
- R6: A load issue clears the valid bit of register `ld_iss_rd` of context `ld_iss_tid`, and a load return sets the valid bit of `ld_ret_rd` of `ld_ret_tid`. When both name the same bit in one cycle, the bit ends cleared.
- R7: With mode bit 3 set, a decoded instruction of the current context switches when an enabled source (`dec_src_en` bit 0 for `dec_src0`, bit 1 for `dec_src1`) names a register whose valid bit is clear. A miss report alone does not switch in this mode.
- R8: With mode bit 4 set, a high `ext_evt` raises `switch_req` in the same cycle.
- R9: A trigger whose mode bit is clear has no effect on `switch_req`.
- R10: `next_tid` is the first context with its `ctx_ready` bit set, searching upward from the current context plus one and wrapping around, never the current context.
- R11: When no context other than the current one is ready, a trigger raises no `switch_req` and `cur_tid` keeps its value.
- R12: After a cycle with `switch_req` high, `flush` is high for exactly one cycle, and in that cycle `cur_tid` equals the `next_tid` presented with the request. No trigger raises `switch_req` while `flush` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 5 | Trigger enables: bit0 explicit, bit1 instruction class, bit2 cache miss, bit3 switch-on-use, bit4 external |
| class_sel | input | 2 | Class selection: bit0 memory, bit1 hard-to-predict branch |
| dec_valid | input | 1 | A decoded instruction of the current context is present |
| dec_is_switch | input | 1 | Decoded instruction is a switch instruction |
| dec_sw_pred_en | input | 1 | Switch instruction carries a predicate |
| dec_sw_cond | input | 1 | Evaluated predicate of the switch instruction |
| dec_is_mem | input | 1 | Decoded instruction is a memory instruction |
| dec_is_hard_br | input | 1 | Decoded instruction is a branch flagged hard to predict |
| dec_src_en | input | 2 | Source operand enables |
| dec_src0 | input | 5 | First source register index |
| dec_src1 | input | 5 | Second source register index |
| miss_rpt | input | 1 | Data-cache miss reported for the current context |
| ext_evt | input | 1 | External event such as an interrupt |
| ld_iss_v | input | 1 | Load issue event |
| ld_iss_tid | input | 2 | Context of the issued load |
| ld_iss_rd | input | 5 | Destination register of the issued load |
| ld_ret_v | input | 1 | Load data return event |
| ld_ret_tid | input | 2 | Context of the returning load |
| ld_ret_rd | input | 5 | Destination register of the returning load |
| ctx_ready | input | 4 | One bit per context that can accept execution |
| switch_req | output | 1 | Context switch requested this cycle |
| next_tid | output | 2 | Context chosen for the switch |
| flush | output | 1 | One-cycle pipeline flush following a switch |
| cur_tid | output | 2 | Context currently running |

## Verification
A wrong valid bit in the scoreboard stays hidden until the current context decodes an instruction that reads that register. At that point `switch_req` shows a spurious or missing switch in that same cycle, so the bench reads registers directly after load issue, collision and return events. A wrong round-robin pick is visible on `next_tid` in the request cycle and on `cur_tid` one cycle later. A stuck or doubled flush shows one cycle after a request, and a wrong flush also blocks or lets through a trigger that was held steady.

// File: rtl/csw_pkg.sv
// Package: shared constants of the thread switch controller.
// Assumes: the mode and class bit positions below are the port encoding.
package csw_pkg;
    localparam int MODE_W      = 5;
    localparam int MODE_EXPL   = 0;
    localparam int MODE_CLASS  = 1;
    localparam int MODE_MISS   = 2;
    localparam int MODE_USE    = 3;
    localparam int MODE_EXT    = 4;
    localparam int CLS_W       = 2;
    localparam int CLS_MEM     = 0;
    localparam int CLS_HARDBR  = 1;
endpackage

// File: rtl/csw_scoreboard.sv
// Module: per-context, per-register valid bits for switch-on-use.
// A load issue clears a bit, a load return sets it; the clear wins on a
// collision. Two read ports report validity for the running context.
// Assumes: synchronous active-low reset marks every bit valid.
module csw_scoreboard #(
    parameter int NCTX = 4,
    parameter int NREG = 32,
    localparam int TID_W = $clog2(NCTX),
    localparam int RA_W  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_v,
    input  logic [TID_W-1:0] iss_tid,
    input  logic [RA_W-1:0]  iss_rd,
    input  logic             ret_v,
    input  logic [TID_W-1:0] ret_tid,
    input  logic [RA_W-1:0]  ret_rd,
    input  logic [TID_W-1:0] rd_tid,
    input  logic [RA_W-1:0]  rd_a0,
    input  logic [RA_W-1:0]  rd_a1,
    output logic             rd_ok0,
    output logic             rd_ok1
);
    logic [NCTX-1:0][NREG-1:0] valid_q;

    for (genvar gc = 0; gc < NCTX; gc++) begin : g_ctx
        for (genvar gr = 0; gr < NREG; gr++) begin : g_reg
            logic hit_iss, hit_ret;
            // Decode whether this bit is addressed by the issue or return event.
            always_comb begin
                hit_iss = iss_v && (iss_tid == TID_W'(gc)) && (iss_rd == RA_W'(gr));
                hit_ret = ret_v && (ret_tid == TID_W'(gc)) && (ret_rd == RA_W'(gr));
            end
            // Update the bit: clear on issue has priority over set on return.
            always_ff @(posedge clk) begin
                if (!rst_n)       valid_q[gc][gr] <= 1'b1;
                else if (hit_iss) valid_q[gc][gr] <= 1'b0;
                else if (hit_ret) valid_q[gc][gr] <= 1'b1;
            end
        end
    end

    // Read the two source bits of the running context.
    always_comb begin
        rd_ok0 = valid_q[rd_tid][rd_a0];
        rd_ok1 = valid_q[rd_tid][rd_a1];
    end
endmodule

// File: rtl/csw_trigger.sv
// Module: combines the enabled switch triggers into one fire signal.
// Assumes: decode fields belong to the running context; block is high in
// the flush cycle, when the decoded instruction is being squashed.
module csw_trigger
    import csw_pkg::*;
(
    input  logic              block,
    input  logic [MODE_W-1:0] mode_en,
    input  logic [CLS_W-1:0]  class_sel,
    input  logic              dec_valid,
    input  logic              dec_is_switch,
    input  logic              dec_sw_pred_en,
    input  logic              dec_sw_cond,
    input  logic              dec_is_mem,
    input  logic              dec_is_hard_br,
    input  logic [1:0]        dec_src_en,
    input  logic              src_ok0,
    input  logic              src_ok1,
    input  logic              miss_rpt,
    input  logic              ext_evt,
    output logic              fire
);
    logic t_expl, t_class, t_miss, t_use, t_ext;

    // Evaluate each trigger under its own enable bit, then merge.
    always_comb begin
        t_expl  = mode_en[MODE_EXPL] && dec_valid && dec_is_switch
                  && (!dec_sw_pred_en || dec_sw_cond);
        t_class = mode_en[MODE_CLASS] && dec_valid
                  && ((class_sel[CLS_MEM] && dec_is_mem)
                      || (class_sel[CLS_HARDBR] && dec_is_hard_br));
        t_miss  = mode_en[MODE_MISS] && miss_rpt;
        t_use   = mode_en[MODE_USE] && dec_valid
                  && ((dec_src_en[0] && !src_ok0) || (dec_src_en[1] && !src_ok1));
        t_ext   = mode_en[MODE_EXT] && ext_evt;
        fire    = !block && (t_expl || t_class || t_miss || t_use || t_ext);
    end
endmodule

// File: rtl/csw_rr_pick.sv
// Module: round-robin choice of the next ready context after the current.
// Assumes: the current context itself is never chosen.
module csw_rr_pick #(
    parameter int NCTX = 4,
    localparam int TID_W = $clog2(NCTX)
) (
    input  logic [TID_W-1:0] cur,
    input  logic [NCTX-1:0]  ready,
    output logic             found,
    output logic [TID_W-1:0] pick
);
    // Scan cur+1, cur+2, ... with wrap and keep the first ready one.
    always_comb begin
        found = 1'b0;
        pick  = cur;
        for (int k = 1; k < NCTX; k++) begin
            logic [TID_W-1:0] idx;
            idx = TID_W'((int'(cur) + k) % NCTX);
            if (!found && ready[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end
endmodule

// File: rtl/thread_switch_ctrl.sv
// Module: top of the coarse-grained thread switch controller.
// Raises switch_req with next_tid in the trigger cycle when another context
// is ready; the next cycle flushes and runs the new context.
// Assumes: decode, miss and source fields refer to the current context.
module thread_switch_ctrl
    import csw_pkg::*;
#(
    parameter int NCTX = 4,
    parameter int NREG = 32,
    localparam int TID_W = $clog2(NCTX),
    localparam int RA_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_en,
    input  logic [CLS_W-1:0]  class_sel,
    input  logic              dec_valid,
    input  logic              dec_is_switch,
    input  logic              dec_sw_pred_en,
    input  logic              dec_sw_cond,
    input  logic              dec_is_mem,
    input  logic              dec_is_hard_br,
    input  logic [1:0]        dec_src_en,
    input  logic [RA_W-1:0]   dec_src0,
    input  logic [RA_W-1:0]   dec_src1,
    input  logic              miss_rpt,
    input  logic              ext_evt,
    input  logic              ld_iss_v,
    input  logic [TID_W-1:0]  ld_iss_tid,
    input  logic [RA_W-1:0]   ld_iss_rd,
    input  logic              ld_ret_v,
    input  logic [TID_W-1:0]  ld_ret_tid,
    input  logic [RA_W-1:0]   ld_ret_rd,
    input  logic [NCTX-1:0]   ctx_ready,
    output logic              switch_req,
    output logic [TID_W-1:0]  next_tid,
    output logic              flush,
    output logic [TID_W-1:0]  cur_tid
);
    logic [TID_W-1:0] cur_q;
    logic             flush_q;
    logic             src_ok0, src_ok1, fire, found;
    logic [TID_W-1:0] pick;

    csw_scoreboard #(.NCTX(NCTX), .NREG(NREG)) i_sb (
        .clk(clk), .rst_n(rst_n),
        .iss_v(ld_iss_v), .iss_tid(ld_iss_tid), .iss_rd(ld_iss_rd),
        .ret_v(ld_ret_v), .ret_tid(ld_ret_tid), .ret_rd(ld_ret_rd),
        .rd_tid(cur_q), .rd_a0(dec_src0), .rd_a1(dec_src1),
        .rd_ok0(src_ok0), .rd_ok1(src_ok1)
    );

    csw_trigger i_trig (
        .block(flush_q), .mode_en(mode_en), .class_sel(class_sel),
        .dec_valid(dec_valid), .dec_is_switch(dec_is_switch),
        .dec_sw_pred_en(dec_sw_pred_en), .dec_sw_cond(dec_sw_cond),
        .dec_is_mem(dec_is_mem), .dec_is_hard_br(dec_is_hard_br),
        .dec_src_en(dec_src_en), .src_ok0(src_ok0), .src_ok1(src_ok1),
        .miss_rpt(miss_rpt), .ext_evt(ext_evt), .fire(fire)
    );

    csw_rr_pick #(.NCTX(NCTX)) i_pick (
        .cur(cur_q), .ready(ctx_ready), .found(found), .pick(pick)
    );

    // Request a switch only when a trigger fires and a target exists.
    always_comb begin
        switch_req = fire && found;
        next_tid   = pick;
    end

    // Register the flush pulse and move to the chosen context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= switch_req;
            if (switch_req) cur_q <= pick;
        end
    end

    assign flush   = flush_q;
    assign cur_tid = cur_q;
endmodule

// File: rtl/csw_ctrl_chk.sv
// Module: assertion checker bound to thread_switch_ctrl.
// Assumes: port names of the top module; observes ports only.
module csw_ctrl_chk
    import csw_pkg::*;
#(
    parameter int NCTX = 4,
    localparam int TID_W = $clog2(NCTX)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_en,
    input logic              miss_rpt,
    input logic              ext_evt,
    input logic [NCTX-1:0]   ctx_ready,
    input logic              switch_req,
    input logic [TID_W-1:0]  next_tid,
    input logic              flush,
    input logic [TID_W-1:0]  cur_tid
);
    logic other_ready;
    // Whether any context besides the current one could be chosen.
    always_comb other_ready = |(ctx_ready & ~(NCTX'(1) << cur_tid));

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (cur_tid == '0 && !flush));
    p_flush_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        switch_req |=> flush);
    p_tid_update_r12: assert property (@(posedge clk) disable iff (!rst_n)
        switch_req |=> (cur_tid == $past(next_tid)));
    p_quiet_in_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !switch_req);
    p_single_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);
    p_stay_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!switch_req && rst_n) |=> $stable(cur_tid));
    p_target_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        switch_req |-> (ctx_ready[next_tid] && next_tid != cur_tid));
    p_no_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !other_ready |-> !switch_req);
    p_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en[MODE_MISS] && miss_rpt && !flush && other_ready) |-> switch_req);
    p_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en[MODE_EXT] && ext_evt && !flush && other_ready) |-> switch_req);
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en == '0) |-> !switch_req);
endmodule

bind thread_switch_ctrl csw_ctrl_chk #(.NCTX(NCTX)) i_chk (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .miss_rpt(miss_rpt),
    .ext_evt(ext_evt), .ctx_ready(ctx_ready), .switch_req(switch_req),
    .next_tid(next_tid), .flush(flush), .cur_tid(cur_tid)
);

// File: tb/test_thread_switch_ctrl.sv
// Bench: a driver applies one cycle of stimulus per call, computes the
// expected outputs from the requirements, and queues them; a monitor
// pops and compares before the next rising edge.
module test_thread_switch_ctrl;
    localparam int NCTX = 4;
    localparam int NREG = 32;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] mode_en;
    logic [1:0] class_sel;
    logic       dec_valid, dec_is_switch, dec_sw_pred_en, dec_sw_cond;
    logic       dec_is_mem, dec_is_hard_br;
    logic [1:0] dec_src_en;
    logic [4:0] dec_src0, dec_src1;
    logic       miss_rpt, ext_evt;
    logic       ld_iss_v, ld_ret_v;
    logic [1:0] ld_iss_tid, ld_ret_tid;
    logic [4:0] ld_iss_rd, ld_ret_rd;
    logic [3:0] ctx_ready;
    logic       switch_req, flush;
    logic [1:0] next_tid, cur_tid;

    thread_switch_ctrl #(.NCTX(NCTX), .NREG(NREG)) i_thread_switch_ctrl (.*);

    always #5 clk = ~clk;

    typedef struct {
        string      tag;
        logic       sw;
        logic [1:0] tid;
        logic [1:0] cur;
        logic       fl;
    } exp_t;
    exp_t q[$];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state built from the requirements.
    bit         m_sb [NCTX][NREG];
    logic [1:0] m_cur;
    bit         m_fl;

    task automatic clear_stim();
        mode_en = 0; class_sel = 0; dec_valid = 0; dec_is_switch = 0;
        dec_sw_pred_en = 0; dec_sw_cond = 0; dec_is_mem = 0; dec_is_hard_br = 0;
        dec_src_en = 0; dec_src0 = 0; dec_src1 = 0; miss_rpt = 0; ext_evt = 0;
        ld_iss_v = 0; ld_iss_tid = 0; ld_iss_rd = 0;
        ld_ret_v = 0; ld_ret_tid = 0; ld_ret_rd = 0; ctx_ready = 4'b1111;
    endtask

    // Driver: stimulus is set by the caller just after a falling edge.
    task automatic step(input string tag, input bit chk);
        bit trig, fnd;
        logic [1:0] pk;
        exp_t e;
        trig = !m_fl && (
            (mode_en[0] && dec_valid && dec_is_switch && (!dec_sw_pred_en || dec_sw_cond)) ||
            (mode_en[1] && dec_valid && ((class_sel[0] && dec_is_mem) || (class_sel[1] && dec_is_hard_br))) ||
            (mode_en[2] && miss_rpt) ||
            (mode_en[3] && dec_valid && ((dec_src_en[0] && !m_sb[m_cur][dec_src0]) ||
                                         (dec_src_en[1] && !m_sb[m_cur][dec_src1]))) ||
            (mode_en[4] && ext_evt));
        fnd = 0; pk = m_cur;
        for (int k = 1; k < NCTX; k++) begin
            logic [1:0] t;
            t = 2'(m_cur + 2'(k));
            if (!fnd && ctx_ready[t]) begin fnd = 1; pk = t; end
        end
        e.tag = tag; e.sw = trig && fnd; e.tid = pk; e.cur = m_cur; e.fl = m_fl;
        if (chk) q.push_back(e);
        // State after the coming rising edge.
        if (!rst_n) begin
            m_cur = 0; m_fl = 0;
            foreach (m_sb[c, r]) m_sb[c][r] = 1;
        end else begin
            m_fl = e.sw;
            if (e.sw) m_cur = pk;
            if (ld_ret_v) m_sb[ld_ret_tid][ld_ret_rd] = 1;
            if (ld_iss_v) m_sb[ld_iss_tid][ld_iss_rd] = 0;
        end
        @(negedge clk);
    endtask

    // Monitor: compare outputs well before the next rising edge.
    always begin
        @(negedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (switch_req !== e.sw || (e.sw && next_tid !== e.tid) ||
                cur_tid !== e.cur || flush !== e.fl) begin
                errors++;
                $display("FAIL %s: got sw=%0b tid=%0d cur=%0d fl=%0b expected sw=%0b tid=%0d cur=%0d fl=%0b",
                         e.tag, switch_req, next_tid, cur_tid, flush, e.sw, e.tid, e.cur, e.fl);
            end
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_stim();
        rst_n = 0;
        m_cur = 0; m_fl = 0;
        @(negedge clk);
        step("reset", 0);
        step("reset", 0);
        rst_n = 1;
        step("R1 reset state", 1);
        // R1: all registers valid after reset, so reads cause no switch.
        mode_en = 5'b01000; dec_valid = 1; dec_src_en = 2'b11; dec_src0 = 3; dec_src1 = 31;
        step("R1 valid after reset", 1);
        clear_stim();
        // R9: every trigger present but all modes disabled.
        dec_valid = 1; dec_is_switch = 1; dec_is_mem = 1; dec_is_hard_br = 1;
        class_sel = 2'b11; miss_rpt = 1; ext_evt = 1;
        step("R9 all disabled", 1);
        mode_en = 5'b00001; dec_is_switch = 0; miss_rpt = 0; ext_evt = 0;
        dec_is_mem = 0; dec_is_hard_br = 0;
        step("R9 explicit mode without switch insn", 1);
        // R2: explicit switch; R12 hold it through the flush cycle.
        dec_is_switch = 1;
        step("R2 explicit switch", 1);
        step("R12 flush blocks held trigger", 1);
        step("R2 switch again after flush", 1);
        clear_stim();
        step("R12 idle after flush", 1);
        step("R12 idle", 1);
        // R3: predicated switch.
        mode_en = 5'b00001; dec_valid = 1; dec_is_switch = 1; dec_sw_pred_en = 1; dec_sw_cond = 0;
        step("R3 predicate false", 1);
        step("R3 predicate false no state change", 1);
        dec_sw_cond = 1;
        step("R3 predicate true", 1);
        clear_stim();
        step("R12 flush", 1);
        // R4: instruction class selection.
        mode_en = 5'b00010; class_sel = 2'b01; dec_valid = 1; dec_is_hard_br = 1;
        step("R4 unselected hard branch", 1);
        dec_is_hard_br = 0; dec_is_mem = 1;
        step("R4 memory class", 1);
        clear_stim();
        step("R12 flush", 1);
        mode_en = 5'b00010; class_sel = 2'b10; dec_valid = 1; dec_is_mem = 1;
        step("R4 unselected memory", 1);
        dec_is_mem = 0; dec_is_hard_br = 1;
        step("R4 hard branch class", 1);
        clear_stim();
        step("R12 flush", 1);
        // R5: cache miss.
        mode_en = 5'b00100; miss_rpt = 1;
        step("R5 miss switch", 1);
        clear_stim();
        step("R12 flush", 1);
        // R8: external event.
        mode_en = 5'b10000; ext_evt = 1;
        step("R8 external switch", 1);
        clear_stim();
        step("R12 flush", 1);
        // R10: skip non-ready contexts with wrap.
        mode_en = 5'b10000; ext_evt = 1; ctx_ready = 4'b0101;
        step("R10 round robin skip", 1);
        clear_stim(); ctx_ready = 4'b0101;
        step("R12 flush", 1);
        mode_en = 5'b10000; ext_evt = 1; ctx_ready = 4'b1001;
        step("R10 round robin wrap", 1);
        clear_stim();
        step("R12 flush", 1);
        // R11: only the current context ready.
        mode_en = 5'b10000; ext_evt = 1; ctx_ready = 4'b0001; ctx_ready[0] = 1'b0;
        ctx_ready = 4'(1) << m_cur;
        step("R11 no other ready", 1);
        step("R11 stay on current", 1);
        clear_stim();
        // R6/R7: switch-on-use.
        mode_en = 5'b01000; ld_iss_v = 1; ld_iss_tid = m_cur; ld_iss_rd = 5;
        step("R6 load issue", 1);
        clear_stim(); mode_en = 5'b01000; miss_rpt = 1;
        step("R7 miss alone no switch", 1);
        miss_rpt = 0; dec_valid = 1; dec_src_en = 2'b01; dec_src0 = 6;
        step("R7 read valid reg", 1);
        dec_src_en = 2'b10; dec_src1 = 5;
        step("R7 read pending reg", 1);
        clear_stim(); mode_en = 5'b01000;
        // Collision on context 2, register 7: clear must win.
        ld_iss_v = 1; ld_iss_tid = 2; ld_iss_rd = 7;
        ld_ret_v = 1; ld_ret_tid = 2; ld_ret_rd = 7;
        step("R6 collision", 1);
        clear_stim();
        // Land on context 2 via external event with only 2 ready.
        mode_en = 5'b10000; ext_evt = 1; ctx_ready = 4'b0100;
        step("R10 go to context 2", 1);
        clear_stim();
        step("R12 flush", 1);
        mode_en = 5'b01000; dec_valid = 1; dec_src_en = 2'b01; dec_src0 = 7;
        step("R6 collision leaves bit clear", 1);
        clear_stim();
        step("R12 flush", 1);
        ld_ret_v = 1; ld_ret_tid = 2; ld_ret_rd = 7;
        step("R6 return", 1);
        clear_stim();
        mode_en = 5'b10000; ext_evt = 1; ctx_ready = 4'b0100;
        step("R10 back to context 2", 1);
        clear_stim();
        step("R12 flush", 1);
        mode_en = 5'b01000; dec_valid = 1; dec_src_en = 2'b11; dec_src0 = 7; dec_src1 = 7;
        step("R6 returned reg valid", 1);
        clear_stim();
        step("R12 idle", 1);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule